// File: doc/BRIEF.md
# Bit-serial GF(2^m) field divider

This block computes the field quotient Q = A / B in GF(2^m). Field elements use the polynomial (standard) basis. The reduction polynomial G is supplied with every operand set rather than fixed in hardware. Operands arrive one coefficient per clock, highest coefficient first, on three serial lines. The quotient leaves on one serial line in the same order. A start strobe marks the first coefficient of each operand set, and a second strobe marks the first coefficient of each result.

Internally the quotient comes from a binary extended GCD that works directly on the dividend, so no inversion step is followed by a multiplication. The state holds two remainder polynomials R and S and two cofactors U and V. Their starting values are R = B, S = G, U = A and V = 0. Each step does one of the following:
- divides R by x and halves U modulo G;
- when R is odd, folds S into R, halves the cofactor sum, and swaps the pair first if R has the lower degree.

After at most 2m steps R is zero, S is one, and V holds the quotient. The steps run in a one-way chain of identical stages. Each stage holds one operand set for m cycles, so operand sets can follow each other with no idle cycles. A result appears every m cycles, at a fixed distance of 5m-2 cycles from its input. The field size m is a parameter.

Top module: `gf2_serial_divider`

## Requirements
- R1: For every B ≠ 0 and every irreducible G of degree m, the serial result Q satisfies Q·B ≡ A (mod G).
- R2: An operand set is m consecutive cycles. The cycle with in_start high carries coefficient m-1 of A, of B and of G. Each of the next m-1 cycles carries the next lower coefficient. The x^m term of G is implied and equal to 1. Successive in_start pulses are at least m cycles apart.
- R3: q_start is high exactly 5m-2 cycles after in_start. In that cycle q_bit carries coefficient m-1 of Q, and each of the following m-1 cycles carries the next lower coefficient.
- R4: Operand sets sent back to back, one every m cycles, give results back to back, one every m cycles, with no idle cycle between them.
- R5: G is taken per operand set. Interleaved operand sets that use different irreducible polynomials each give the quotient under their own G.
- R6: During reset, and in every cycle outside a result window, q_start and q_bit are 0.
- R7: A = 0 gives Q = 0.
- R8: A = B gives Q = 1.
- R9: B = 1 gives Q = A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_start | input | 1 | High in the first cycle of an operand set |
| a_bit | input | 1 | Dividend coefficient, highest first |
| b_bit | input | 1 | Divisor coefficient, highest first |
| g_bit | input | 1 | Reduction polynomial coefficient m-1 down to 0 |
| q_start | output | 1 | High in the first cycle of a result |
| q_bit | output | 1 | Quotient coefficient, highest first |

## Verification
The assertions take for granted that in_start pulses are never closer than m cycles, that every B is nonzero, and that every G is irreducible with an odd constant term. Given those conditions, the divider's timing is fixed: every start pulse leads to one result strobe, and result strobes keep the same spacing. The stimulus keeps within these limits in three ways. Every frame lasts exactly m cycles, with optional gaps after it. Pseudo-random divisors are forced nonzero. Only two known irreducible octic polynomials are used, alternated from frame to frame.

// File: rtl/gf2div_pkg.sv
package gf2div_pkg;

   // Number of iterating stages; each holds a frame for m cycles and performs
   // m GCD steps, so two stages cover the 2m steps a division can need.
   localparam int GCD_STAGES = 2;

   // Kind of step a cell applies to the current GCD state.
   typedef enum logic [1:0] {
      STEP_HOLD      = 2'd0,  // R already zero: the quotient sits in V
      STEP_HALVE     = 2'd1,  // R even: R/x, U/x mod G
      STEP_FOLD      = 2'd2,  // R odd, deg R >= deg S: fold S into R
      STEP_SWAP_FOLD = 2'd3   // R odd, deg R <  deg S: swap then fold
   } gcd_step_e;

   // Fixed input-to-output distance of the divider in cycles.
   function automatic int frame_latency(input int m);
      return 5 * m - 2;
   endfunction

endpackage

// File: rtl/gf2div_deser.sv
module gf2div_deser #(
   parameter int M = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start_i,
   input  logic         a_i,
   input  logic         b_i,
   input  logic         g_i,
   output logic         load_o,
   output logic [M-1:0] a_o,
   output logic [M-1:0] b_o,
   output logic [M-1:0] g_o
);
   localparam int CW = (M > 1) ? $clog2(M) : 1;

   logic [CW-1:0] cnt_q;
   logic          busy_q;
   logic [CW-1:0] pos;
   logic [M-2:0]  a_sh, b_sh, g_sh;

   assign pos    = start_i ? '0 : cnt_q;
   assign load_o = (start_i | busy_q) & (pos == CW'(M - 1));

   // The last coefficient is taken straight from the pins.
   assign a_o = {a_sh, a_i};
   assign b_o = {b_sh, b_i};
   assign g_o = {g_sh, g_i};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         busy_q <= 1'b0;
         a_sh   <= '0;
         b_sh   <= '0;
         g_sh   <= '0;
      end else begin
         if (start_i) begin
            cnt_q  <= CW'(1);
            busy_q <= 1'b1;
         end else if (busy_q) begin
            if (cnt_q == CW'(M - 1)) busy_q <= 1'b0;
            cnt_q <= cnt_q + CW'(1);
         end
         a_sh <= {a_sh[M-3:0], a_i};
         b_sh <= {b_sh[M-3:0], b_i};
         g_sh <= {g_sh[M-3:0], g_i};
      end
   end

endmodule

// File: rtl/gf2div_step_cell.sv
module gf2div_step_cell
   import gf2div_pkg::*;
#(
   parameter int M = 8
) (
   input  logic [M-1:0] g_i,
   input  logic [M:0]   r_i,
   input  logic [M:0]   s_i,
   input  logic [M-1:0] u_i,
   input  logic [M-1:0] v_i,
   output logic [M:0]   r_o,
   output logic [M:0]   s_o,
   output logic [M-1:0] u_o,
   output logic [M-1:0] v_o
);
   gcd_step_e   kind;
   logic [M:0]  r_fold;
   logic [M-1:0] u_half, uv_half;

   // Division by x modulo G: add G when the constant term is set, then shift.
   function automatic logic [M-1:0] half_mod(input logic [M-1:0] w,
                                             input logic [M-1:0] g);
      logic [M:0] t;
      t = {1'b0, w} ^ ({(M + 1){w[0]}} & {1'b1, g});
      return t[M:1];
   endfunction

   always_comb begin
      if (r_i == '0)
         kind = STEP_HOLD;
      else if (!r_i[0])
         kind = STEP_HALVE;
      // S has a term above the top of R exactly when S&~R exceeds R.
      else if (r_i < (s_i & ~r_i))
         kind = STEP_SWAP_FOLD;
      else
         kind = STEP_FOLD;
   end

   assign r_fold  = (r_i ^ s_i) >> 1;
   assign u_half  = half_mod(u_i, g_i);
   assign uv_half = half_mod(u_i ^ v_i, g_i);

   always_comb begin
      r_o = r_i;
      s_o = s_i;
      u_o = u_i;
      v_o = v_i;
      unique case (kind)
         STEP_HOLD: ;
         STEP_HALVE: begin
            r_o = r_i >> 1;
            u_o = u_half;
         end
         STEP_FOLD: begin
            r_o = r_fold;
            u_o = uv_half;
         end
         STEP_SWAP_FOLD: begin
            r_o = r_fold;
            u_o = uv_half;
            s_o = r_i;
            v_o = u_i;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/gf2div_stage.sv
module gf2div_stage #(
   parameter int M  = 8,
   parameter int SW = 5 * M + 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [SW-1:0] st_i,
   output logic [SW-1:0] st_o,
   output logic          pass_o
);
   localparam int CW = (M > 1) ? $clog2(M) : 1;

   typedef struct packed {
      logic [M-1:0] g;
      logic [M:0]   r;
      logic [M:0]   s;
      logic [M-1:0] u;
      logic [M-1:0] v;
   } gcd_state_t;

   gcd_state_t    src, nxt, st_q;
   logic [CW-1:0] cnt_q;
   logic          busy_q;

   // A fresh frame takes its first step on the loading edge itself.
   assign src = load_i ? gcd_state_t'(st_i) : st_q;

   gf2div_step_cell #(.M(M)) i_cell (
      .g_i (src.g),
      .r_i (src.r),
      .s_i (src.s),
      .u_i (src.u),
      .v_i (src.v),
      .r_o (nxt.r),
      .s_o (nxt.s),
      .u_o (nxt.u),
      .v_o (nxt.v)
   );
   assign nxt.g = src.g;

   assign st_o   = st_q;
   assign pass_o = busy_q & (cnt_q == CW'(M - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= '0;
         cnt_q  <= '0;
         busy_q <= 1'b0;
      end else begin
         st_q <= nxt;
         if (load_i) begin
            cnt_q  <= '0;
            busy_q <= 1'b1;
         end else if (busy_q) begin
            if (cnt_q == CW'(M - 1)) busy_q <= 1'b0;
            cnt_q <= cnt_q + CW'(1);
         end
      end
   end

endmodule

// File: rtl/gf2div_serout.sv
module gf2div_serout #(
   parameter int M   = 8,
   parameter int DLY = 2 * M - 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [M-1:0] word_i,
   output logic         start_o,
   output logic         bit_o
);
   logic [M-1:0] sh_q;
   logic         st_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q <= '0;
         st_q <= 1'b0;
      end else begin
         st_q <= load_i;
         if (load_i) sh_q <= word_i;
         else        sh_q <= {sh_q[M-2:0], 1'b0};
      end
   end

   // Alignment to the fixed frame latency.
   generate
      if (DLY == 0) begin : g_direct
         assign start_o = st_q;
         assign bit_o   = sh_q[M-1];
      end else begin : g_delay
         logic [DLY-1:0] ds_q, db_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ds_q <= '0;
               db_q <= '0;
            end else begin
               ds_q <= {ds_q[DLY-2+((DLY==1)?1:0):0], st_q} ;
               db_q <= {db_q[DLY-2+((DLY==1)?1:0):0], sh_q[M-1]};
            end
         end
         assign start_o = ds_q[DLY-1];
         assign bit_o   = db_q[DLY-1];
      end
   endgenerate

endmodule

// File: rtl/gf2_serial_divider.sv
module gf2_serial_divider
   import gf2div_pkg::*;
#(
   parameter int M = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_start,
   input  logic a_bit,
   input  logic b_bit,
   input  logic g_bit,
   output logic q_start,
   output logic q_bit
);
   localparam int NSTAGE = GCD_STAGES;
   localparam int SW     = 5 * M + 2;
   localparam int LAT    = frame_latency(M);
   localparam int DLY    = LAT - (NSTAGE + 1) * M;

   generate
      if (M < 3) begin : g_bad_m
         $error("gf2_serial_divider: M must be at least 3");
      end
      if (DLY < 0) begin : g_bad_dly
         $error("gf2_serial_divider: stage count exceeds latency budget");
      end
   endgenerate

   logic          in_load;
   logic [M-1:0]  a_w, b_w, g_w;
   logic [NSTAGE:0] ld;
   logic [SW-1:0] st [NSTAGE+1];

   gf2div_deser #(.M(M)) i_deser (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (in_start),
      .a_i     (a_bit),
      .b_i     (b_bit),
      .g_i     (g_bit),
      .load_o  (in_load),
      .a_o     (a_w),
      .b_o     (b_w),
      .g_o     (g_w)
   );

   // Start state {G, R=B, S=G, U=A, V=0}; x^m of S is implied.
   assign ld[0] = in_load;
   assign st[0] = {g_w, 1'b0, b_w, 1'b1, g_w, a_w, {M{1'b0}}};

   generate
      for (genvar i = 0; i < NSTAGE; i++) begin : g_stage
         gf2div_stage #(.M(M), .SW(SW)) i_stage (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_i (ld[i]),
            .st_i   (st[i]),
            .st_o   (st[i+1]),
            .pass_o (ld[i+1])
         );
      end
   endgenerate

   gf2div_serout #(.M(M), .DLY(DLY)) i_serout (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (ld[NSTAGE]),
      .word_i  (st[NSTAGE][M-1:0]),
      .start_o (q_start),
      .bit_o   (q_bit)
   );

endmodule

// File: rtl/gf2_serial_divider_chk.sv
module gf2_serial_divider_chk #(
   parameter int M = 8
) (
   input logic clk,
   input logic rst_n,
   input logic in_start,
   input logic q_start,
   input logic q_bit
);
   localparam int L  = 5 * M - 2;
   localparam int GW = $clog2(M + 1);

   logic [L-1:0]  lat_sr;
   logic [GW-1:0] gap_in, gap_out;
   logic          seen_out;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_sr   <= '0;
         gap_in   <= GW'(M);
         gap_out  <= GW'(M);
         seen_out <= 1'b0;
      end else begin
         lat_sr <= {lat_sr[L-2:0], in_start};
         if (in_start)                gap_in <= GW'(1);
         else if (gap_in != GW'(M))   gap_in <= gap_in + GW'(1);
         if (q_start)                 gap_out <= GW'(1);
         else if (gap_out != GW'(M))  gap_out <= gap_out + GW'(1);
         if (q_start) seen_out <= 1'b1;
      end
   end

   // R2: operand frames never overlap
   a_r2_start_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      in_start |-> (gap_in == GW'(M)));

   // R3: each start strobe yields a result strobe exactly 5m-2 cycles later
   a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
      q_start == lat_sr[L-1]);

   // R4: result strobes are at least m cycles apart
   a_r4_result_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      q_start |-> (gap_out == GW'(M)));

   // R6: outputs quiet during reset
   a_r6_reset_quiet: assert property (@(posedge clk)
      !rst_n |-> (!q_start && !q_bit));

   // R6: no data before the first result window
   a_r6_quiet_before_first: assert property (@(posedge clk) disable iff (!rst_n)
      (!seen_out && !q_start) |-> !q_bit);

endmodule

bind gf2_serial_divider gf2_serial_divider_chk #(.M(M)) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_start (in_start),
   .q_start  (q_start),
   .q_bit    (q_bit)
);

// File: tb/test_gf2_serial_divider.sv
module test_gf2_serial_divider;
   localparam int M   = 8;
   localparam int LAT = 5 * M - 2;
   localparam int G1  = 'h1B;   // x^8+x^4+x^3+x+1
   localparam int G2  = 'h1D;   // x^8+x^4+x^3+x^2+1

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_start = 1'b0, a_bit = 1'b0, b_bit = 1'b0, g_bit = 1'b0;
   logic q_start, q_bit;

   int compared = 0, mismatched = 0, cyc = 0;
   bit done = 1'b0;

   bit    exp_s [int];
   bit    exp_b [int];
   string exp_t [int];
   int    fa[$], fb[$], fg[$];
   string ft[$];

   always #4 clk = ~clk;   // 125 MHz

   gf2_serial_divider #(.M(M)) i_gf2_serial_divider (
      .clk (clk), .rst_n (rst_n), .in_start (in_start),
      .a_bit (a_bit), .b_bit (b_bit), .g_bit (g_bit),
      .q_start (q_start), .q_bit (q_bit)
   );

   always @(posedge clk) cyc <= cyc + 1;

   function automatic int gmul(int a, int b, int g);
      int p = 0;
      for (int i = M - 1; i >= 0; i--) begin
         p = p << 1;
         if (p[M]) p = p ^ ((1 << M) | g);
         if (b[i]) p = p ^ a;
      end
      return p;
   endfunction

   function automatic int ginv(int b, int g);
      for (int c = 1; c < (1 << M); c++)
         if (gmul(b, c, g) == 1) return c;
      return 0;
   endfunction

   // Cycle-by-cycle comparison against the scheduled reference stream.
   int  col_n = 0, col_w = 0;
   bit  col_on = 1'b0;
   always @(negedge clk) begin
      bit es, eb;
      string t;
      es = exp_s.exists(cyc) ? exp_s[cyc] : 1'b0;
      eb = exp_b.exists(cyc) ? exp_b[cyc] : 1'b0;
      t  = exp_t.exists(cyc) ? exp_t[cyc] : "R6";
      compared++;
      if (q_start !== es || q_bit !== eb) begin
         mismatched++;
         $display("FAIL %s/R3 cycle %0d: q_start=%b q_bit=%b expected %b %b",
                  t, cyc, q_start, q_bit, es, eb);
      end
      if (q_start === 1'b1) begin
         col_on = 1'b1; col_n = 1; col_w = int'(q_bit);
      end else if (col_on) begin
         col_w = (col_w << 1) | int'(q_bit); col_n++;
      end
      if (col_on && col_n == M) begin
         col_on = 1'b0;
         if (fa.size() > 0) begin
            int a = fa.pop_front(), b = fb.pop_front(), g = fg.pop_front();
            string tt = ft.pop_front();
            compared++;
            if (gmul(col_w, b, g) != a) begin
               mismatched++;
               $display("FAIL R1 (%s) Q*B mod G: got %0h expected %0h", tt,
                        gmul(col_w, b, g), a);
            end
         end
      end
   end

   task automatic send(int a, int b, int g, int gap, string tag);
      int q, s;
      q = gmul(a, ginv(b, g), g);
      for (int i = 0; i < M; i++) begin
         @(negedge clk);
         if (i == 0) begin
            s = cyc;
            for (int j = 0; j < M; j++) begin
               exp_s[s + LAT + j] = (j == 0);
               exp_b[s + LAT + j] = q[M-1-j];
               exp_t[s + LAT + j] = tag;
            end
            fa.push_back(a); fb.push_back(b); fg.push_back(g); ft.push_back(tag);
         end
         in_start = (i == 0);
         a_bit = a[M-1-i]; b_bit = b[M-1-i]; g_bit = g[M-1-i];
      end
      for (int k = 0; k < gap; k++) begin
         @(negedge clk);
         in_start = 0; a_bit = 0; b_bit = 0; g_bit = 0;
      end
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   endtask

   initial begin
      int x = 7;
      repeat (4) @(negedge clk);   // R6: reset cycles compared as quiet
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      send(0, 'h53, G1, 2, "R7");            // R7: zero dividend
      send('hC9, 'hC9, G1, 0, "R8");         // R8: equal operands
      send('hA5, 1, G1, 5, "R9");            // R9: unit divisor
      send('hFF, 'h80, G1, 1, "R2");         // R2: top coefficients set
      send('h01, 'hFF, G2, 3, "R2");
      for (int n = 0; n < 16; n++) begin     // R4 back to back, R5 alternating G
         int a, b;
         x = x * 1103515245 + 12345;
         a = (x >> 8) & 'hFF;
         b = (x >> 16) & 'hFF;
         if (b == 0) b = 1;
         send(a, b, (n % 2) ? G2 : G1, 0, (n % 2) ? "R5" : "R4");
      end
      send('h3C, 'h02, G2, 0, "R1");
      send('h80, 'h57, G1, 0, "R1");
      repeat (LAT + 2 * M) @(negedge clk);   // R6: idle after the last window
      done = 1'b1;
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         mismatched++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

endmodule